// File: doc/BRIEF.md
# Programmable Divider Timer with Delayed Reload

This block is a small timer that sits on the I/O side of an 8-bit processor bus. A 16-bit divider counts every clock cycle without pause. One of four of its bits is chosen as a tap, and each falling edge of that tap advances an 8-bit count register, provided counting is enabled. Software sees four byte-wide registers in a row: the upper byte of the divider, the count, a reload (modulo) value and a 3-bit control field.

When the count passes 0xFF it wraps to 0x00. It does not reload at once. It stays at zero for four cycles. On the fifth edge it takes the reload value and raises a single-cycle interrupt request. That request is meant to drive bit 2 (mask 0x04) of an external interrupt flag register.

If software writes the count register while the count is held at zero, the pending reload and its interrupt are dropped. Reads are registered. The bus read data shows the register addressed in the previous cycle.

Top module: `prog_div_timer`

## Requirements
- R1: The divider increases by one every clock cycle and wraps at 2^16. Any write to offset 0 clears it to zero. A read of offset 0 returns divider bits 15:8.
- R2: The control field is 3 bits wide and sits at offset 3. Bit 2 enables counting. Bits 1:0 choose the tap. A read of offset 3 returns the stored field in bits 2:0 and ones in bits 7:3.
- R3: A read of the count (offset 1) or of the reload value (offset 2) returns the byte last written there. Read data appears on the clock edge after the address is presented.
- R4: While enabled, the count steps once per falling edge of the chosen divider bit. Tap code 00 selects bit 9 (one step per 1024 cycles), 01 selects bit 3 (16 cycles), 10 selects bit 5 (64 cycles) and 11 selects bit 7 (256 cycles).
- R5: With control bit 2 clear, the count does not change.
- R6: A step from 0xFF leaves the count at 0x00 for exactly four cycles. On the next edge it loads the reload value.
- R7: The interrupt request is high for exactly one cycle, in the cycle the reload value first appears, four cycles after the wrap and not at the wrap.
- R8: A bus write to the count while it is held at zero stores the written byte. It cancels both the reload and the interrupt.
- R9: After reset the count, the reload value, the control field, the divider and the interrupt request are all zero. The control read therefore returns 0xF8.
- R10: Addresses outside the four-register window read as 0xFF, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | I/O address; the window starts at parameter BASE (0x04) |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |
| irq_req | output | 1 | One-cycle interrupt request at reload |

## Verification
On every cycle, the assertions check the following:
- the divider advances by one, or clears after a write to it;
- each tap step adds one to the count;
- a wrap lands on zero;
- the interrupt pulse lasts one cycle and follows a held zero;
- a write during the hold suppresses the pulse;
- control reads carry ones in the upper bits.

The step interval for each tap code can only be shown by the bench's scenarios. The same holds for the exact cycle of the reload relative to the wrap, for the disabled case and for the unmapped window. The bench also checks random write/readback traffic against its own model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Register slot within the four-byte window; order is decoded by software.
  typedef enum logic [1:0] {
    SLOT_DIV = 2'd0,
    SLOT_CNT = 2'd1,
    SLOT_MOD = 2'd2,
    SLOT_CTL = 2'd3
  } slot_e;

  localparam int NUM_TAPS = 4;

  // Divider bit watched for each tap code.
  function automatic int tap_index(input logic [1:0] code);
    case (code)
      2'b00:   return 9;
      2'b01:   return 3;
      2'b10:   return 5;
      default: return 7;
    endcase
  endfunction

endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [DIV_W-1:0] div_q
);

  always_ff @(posedge clk) begin
    if (rst || clr) div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/tmr_tap_edge.sv
module tmr_tap_edge #(
  parameter int NUM_TAPS = 4,
  parameter int SEL_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TAPS-1:0] tap_now,
  input  logic [SEL_W-1:0]    tap_sel,
  input  logic                enable,
  output logic                step
);

  logic [NUM_TAPS-1:0] tap_prev_q;
  logic [NUM_TAPS-1:0] fall;

  // History is kept per tap, so changing the selection cannot fake an edge.
  always_ff @(posedge clk) begin
    if (rst) tap_prev_q <= '0;
    else     tap_prev_q <= tap_now;
  end

  assign fall = tap_prev_q & ~tap_now;
  assign step = enable & fall[tap_sel];

endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit #(
  parameter int CNT_W = 8,
  parameter int HOLD  = 4,
  localparam int PW   = $clog2(HOLD + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             wr_cnt,
  input  logic             wr_mod,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] mod_q,
  output logic [PW-1:0]    pend_q,
  output logic             irq_q
);

  logic [CNT_W-1:0] reload_val;

  // A modulo write on the reload edge is forwarded.
  assign reload_val = wr_mod ? wdata : mod_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mod_q  <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (wr_mod) mod_q <= wdata;
      if (wr_cnt) begin
        cnt_q  <= wdata;
        pend_q <= '0;
      end else if (pend_q != '0) begin
        if (pend_q == PW'(1)) begin
          cnt_q <= reload_val;
          irq_q <= 1'b1;
        end
        pend_q <= pend_q - 1'b1;
      end else if (step) begin
        if (cnt_q == '1) begin
          cnt_q  <= '0;
          pend_q <= PW'(HOLD);
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/prog_div_timer.sv
module prog_div_timer #(
  parameter int              ADDR_W = 8,
  parameter int              DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h04,
  parameter int              DIV_W  = 16,
  parameter int              CTL_W  = 3,
  parameter int              HOLD   = 4,
  localparam int             PW     = $clog2(HOLD + 1),
  localparam int             SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_req
);
  import tmr_pkg::*;

  logic [ADDR_W-1:0]   rel;
  logic                in_win;
  slot_e               slot;
  logic                wr_div, wr_cnt, wr_mod, wr_ctl, hit_ctl;
  logic [DIV_W-1:0]    div_q;
  logic [NUM_TAPS-1:0] tap_now;
  logic [CTL_W-1:0]    ctl_q;
  logic                step;
  logic [DATA_W-1:0]   cnt_q, mod_q;
  logic [PW-1:0]       pend_q;
  logic [DATA_W-1:0]   rd_mux;

  assign rel    = bus_addr - BASE;
  assign in_win = (bus_addr >= BASE) && (rel < ADDR_W'(NUM_TAPS));
  assign slot   = slot_e'(rel[1:0]);

  assign wr_div  = bus_wr && in_win && (slot == SLOT_DIV);
  assign wr_cnt  = bus_wr && in_win && (slot == SLOT_CNT);
  assign wr_mod  = bus_wr && in_win && (slot == SLOT_MOD);
  assign wr_ctl  = bus_wr && in_win && (slot == SLOT_CTL);
  assign hit_ctl = in_win && (slot == SLOT_CTL);

  tmr_divider #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .clr   (wr_div),
    .div_q (div_q)
  );

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int TI = tap_index(2'(g));
    assign tap_now[g] = div_q[TI];
  end

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (wr_ctl) ctl_q <= bus_wdata[CTL_W-1:0];
  end

  tmr_tap_edge #(.NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .tap_now (tap_now),
    .tap_sel (ctl_q[SEL_W-1:0]),
    .enable  (ctl_q[CTL_W-1]),
    .step    (step)
  );

  tmr_count_unit #(.CNT_W(DATA_W), .HOLD(HOLD)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .wr_cnt (wr_cnt),
    .wr_mod (wr_mod),
    .wdata  (bus_wdata),
    .cnt_q  (cnt_q),
    .mod_q  (mod_q),
    .pend_q (pend_q),
    .irq_q  (irq_req)
  );

  always_comb begin
    rd_mux = '1;
    if (in_win) begin
      case (slot)
        SLOT_DIV: rd_mux = div_q[DIV_W-1 -: DATA_W];
        SLOT_CNT: rd_mux = cnt_q;
        SLOT_MOD: rd_mux = mod_q;
        default:  rd_mux = {{(DATA_W-CTL_W){1'b1}}, ctl_q};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  parameter int CTL_W  = 3,
  parameter int PW     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [DIV_W-1:0]  div_q,
  input logic              wr_div,
  input logic              wr_cnt,
  input logic              hit_ctl,
  input logic              step,
  input logic [DATA_W-1:0] cnt_q,
  input logic [PW-1:0]     pend_q,
  input logic              irq,
  input logic [DATA_W-1:0] rdata
);

  // R1
  a_r1_div_inc: assert property (@(posedge clk) disable iff (rst)
    !wr_div |=> div_q == DIV_W'($past(div_q) + 1'b1));

  // R1
  a_r1_div_clear: assert property (@(posedge clk) disable iff (rst)
    wr_div |=> div_q == '0);

  // R2
  a_r2_ctl_ones: assert property (@(posedge clk) disable iff (rst)
    hit_ctl |=> rdata[DATA_W-1:CTL_W] == '1);

  // R4
  a_r4_step_inc: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_cnt && pend_q == '0 && cnt_q != '1)
      |=> cnt_q == DATA_W'($past(cnt_q) + 1'b1));

  // R6
  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_cnt && pend_q == '0 && cnt_q == '1) |=> cnt_q == '0);

  // R7
  a_r7_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R7
  a_r7_irq_after_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(cnt_q) == '0);

  // R8
  a_r8_cancel: assert property (@(posedge clk) disable iff (rst)
    (wr_cnt && pend_q != '0) |=> !irq);

endmodule

bind prog_div_timer tmr_checker #(
  .DIV_W(DIV_W), .DATA_W(DATA_W), .CTL_W(CTL_W), .PW(PW)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .div_q   (div_q),
  .wr_div  (wr_div),
  .wr_cnt  (wr_cnt),
  .hit_ctl (hit_ctl),
  .step    (step),
  .cnt_q   (cnt_q),
  .pend_q  (pend_q),
  .irq     (irq_req),
  .rdata   (bus_rdata)
);

// File: tb/sim_prog_div_timer.sv
`timescale 1ns/1ps
module sim_prog_div_timer;

  localparam logic [7:0] A_DIV = 8'h04;
  localparam logic [7:0] A_CNT = 8'h05;
  localparam logic [7:0] A_MOD = 8'h06;
  localparam logic [7:0] A_CTL = 8'h07;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = 8'h00;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prog_div_timer u0 (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (addr),
    .bus_wr    (wr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq_req   (irq)
  );

  function automatic int tap_bit(input int code);
    case (code)
      0:       return 9;
      1:       return 3;
      2:       return 5;
      default: return 7;
    endcase
  endfunction

  function automatic logic [7:0] ctl_read(input logic [2:0] v);
    return {5'b11111, v};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    @(posedge clk);
    #1 v = rdata;
  endtask

  task automatic measure_tap(input int code);
    logic [7:0] v, last;
    int per, t, n;
    int times[3];
    per = 1 << (tap_bit(code) + 1);
    bus_write(A_CTL, 8'(4 + code));
    bus_write(A_CNT, 8'h00);
    bus_read(A_CNT, last);
    n = 0; t = 0;
    for (int i = 0; i < 4 * per + 64 && n < 3; i++) begin
      @(posedge clk); #1;
      t++;
      v = rdata;
      if (v != last) begin
        times[n] = t;
        n++;
        last = v;
      end
    end
    check(n == 3, "R4 tap steps seen", n, 3);
    if (n == 3) begin
      check(times[1] - times[0] == per, "R4 tap interval a", times[1] - times[0], per);
      check(times[2] - times[1] == per, "R4 tap interval b", times[2] - times[1], per);
    end
    bus_write(A_CTL, 8'h00);
  endtask

  task automatic wait_wrap(output bit ok);
    int n;
    ok = 1'b0;
    n = 0;
    @(negedge clk);
    addr = A_CNT;
    while (n < 200 && rdata != 8'hFF) begin @(posedge clk); #1; n++; end
    while (n < 200 && rdata != 8'h00) begin @(posedge clk); #1; n++; end
    ok = (rdata == 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, m, d;
    bit ok, is_cnt;
    logic [7:0] exp_cnt, exp_mod;
    int irq_hits;
    void'($urandom(32'd4711));

    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R9 reset state
    check(irq == 1'b0, "R9 irq after reset", irq, 0);
    bus_read(A_CNT, v); check(v == 8'h00, "R9 count reset", v, 0);
    bus_read(A_MOD, v); check(v == 8'h00, "R9 modulo reset", v, 0);
    bus_read(A_CTL, v); check(v == 8'hF8, "R9 control reset", v, 8'hF8);

    // R2 control readback with forced upper ones
    bus_write(A_CTL, 8'h05); bus_read(A_CTL, v);
    check(v == ctl_read(3'd5), "R2 ctl 05", v, ctl_read(3'd5));
    bus_write(A_CTL, 8'h02); bus_read(A_CTL, v);
    check(v == ctl_read(3'd2), "R2 ctl 02", v, ctl_read(3'd2));
    bus_write(A_CTL, 8'h00);

    // R1 divider clear and upper-byte read
    bus_write(A_DIV, 8'h5A);
    bus_read(A_DIV, v); check(v == 8'h00, "R1 div cleared", v, 0);
    bus_write(A_DIV, 8'h00);
    repeat (1000) @(posedge clk);
    bus_read(A_DIV, v); check(v == 8'(1001 >> 8), "R1 div upper byte", v, 1001 >> 8);

    // R3 random readback of count and modulo, counting disabled
    bus_write(A_CTL, 8'h01);
    exp_cnt = 8'h00; exp_mod = 8'h00;
    for (int i = 0; i < 16; i++) begin
      d = 8'($urandom);
      is_cnt = 1'($urandom);
      bus_write(is_cnt ? A_CNT : A_MOD, d);
      if (is_cnt) exp_cnt = d; else exp_mod = d;
      bus_read(A_CNT, v); check(v == exp_cnt, "R3 count readback", v, exp_cnt);
      bus_read(A_MOD, v); check(v == exp_mod, "R3 modulo readback", v, exp_mod);
    end

    // R5 disabled count holds
    bus_write(A_CNT, 8'h40);
    repeat (300) @(posedge clk);
    bus_read(A_CNT, v); check(v == 8'h40, "R5 disabled count", v, 8'h40);

    // R10 unmapped window
    bus_write(8'h08, 8'h99);
    bus_write(8'h03, 8'h11);
    bus_read(8'h08, v); check(v == 8'hFF, "R10 unmapped read 08", v, 8'hFF);
    bus_read(8'h03, v); check(v == 8'hFF, "R10 unmapped read 03", v, 8'hFF);
    bus_read(A_CNT, v); check(v == 8'h40, "R10 count untouched", v, 8'h40);
    bus_read(A_MOD, v); check(v == exp_mod, "R10 modulo untouched", v, exp_mod);

    // R4 step interval for every tap code
    for (int c = 0; c < 4; c++) measure_tap(c);

    // R6 R7 wrap, hold, reload and interrupt timing
    for (int k = 0; k < 3; k++) begin
      m = 8'($urandom_range(1, 254));
      bus_write(A_CTL, 8'h05);
      bus_write(A_MOD, m);
      bus_write(A_CNT, 8'hFF);
      wait_wrap(ok);
      check(ok, "R6 wrap to zero", rdata, 0);
      check(irq == 1'b0, "R7 no irq at wrap", irq, 0);
      for (int c = 1; c <= 4; c++) begin
        @(posedge clk); #1;
        if (c < 4) check(rdata == 8'h00, "R6 held zero", rdata, 0);
        else       check(rdata == m, "R6 reload value", rdata, m);
        check(irq == (c == 3), "R7 irq cycle", irq, int'(c == 3));
      end
      bus_write(A_CTL, 8'h00);
    end

    // R8 write during hold cancels reload and interrupt
    bus_write(A_CTL, 8'h05);
    bus_write(A_MOD, 8'h77);
    bus_write(A_CNT, 8'hFF);
    wait_wrap(ok);
    check(ok, "R8 wrap seen", rdata, 0);
    irq_hits = 0;
    fork
      begin
        for (int i = 0; i < 12; i++) begin @(posedge clk); #1; if (irq) irq_hits++; end
      end
      begin
        bus_write(A_CNT, 8'h33);
        bus_read(A_CNT, v);
      end
    join
    check(v == 8'h33, "R8 written value kept", v, 8'h33);
    check(irq_hits == 0, "R8 irq cancelled", irq_hits, 0);
    bus_write(A_CTL, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule